// File: doc/BRIEF.md
# Warp Issue Gate with Pending-Write Scoreboard

This block sits between instruction fetch and issue for a single warp. Fetched instructions, each carrying up to two source register ids, an optional destination register id and an opaque payload, are queued in a small in-order buffer. A compact scoreboard keeps a handful of register ids whose writes are still in flight. The oldest buffered instruction is offered on the issue port only when none of its enabled sources and none of its destination match an in-flight id. It also needs a free scoreboard slot if it writes a register.

On issue, the destination id of the instruction claims a scoreboard slot. A writeback port releases the slot that holds a given id. The release is visible to the issue decision in the same cycle, so a waiting consumer can leave on the cycle its producer completes. When the buffer is full, fetch is stalled, and anything offered during the stall is dropped.

Top module: `warp_issue_gate`

## Requirements
- R1: After reset the buffer is empty (`issue_valid` low, `fetch_stall` low) and no register id is pending; an id that was pending before reset no longer blocks an instruction.
- R2: A fetch with `fetch_valid` high while `fetch_stall` is low is stored in the buffer at the clock edge.
- R3: `fetch_stall` is high exactly when the buffer holds DEPTH instructions; a fetch offered while it is high is not stored.
- R4: Instructions leave in fetch order; only the oldest is considered, so a hazard-free younger instruction never issues ahead of a blocked older one.
- R5: The oldest instruction is not offered while an enabled source id (bit s of `fetch_src_en` enables the source at bits [s*RW +: RW] of `fetch_src`) matches a pending id.
- R6: The oldest instruction with `fetch_has_dst` high is not offered while its destination id matches a pending id.
- R7: An issued instruction with `has_dst` high makes its destination id pending from the next cycle.
- R8: With all SB_ENTRIES slots pending, an instruction with `has_dst` high is held, while one with `has_dst` low may still issue.
- R9: `wb_valid` with `wb_reg` releases the slot holding that id; the release counts for the issue decision of the same cycle.
- R10: Once `issue_valid` is high and `issue_ready` low, `issue_valid` stays high with unchanged issue fields in the next cycle.
- R11: A source whose enable bit is low is never compared against pending ids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_src | input | NSRC*RW | Source register ids, source s at [s*RW +: RW] |
| fetch_src_en | input | NSRC | Per-source enable |
| fetch_dst | input | RW | Destination register id |
| fetch_has_dst | input | 1 | Instruction writes `fetch_dst` |
| fetch_payload | input | PW | Opaque instruction bits |
| fetch_stall | output | 1 | Buffer full, fetch not accepted |
| wb_valid | input | 1 | A write has completed |
| wb_reg | input | RW | Register id of the completed write |
| issue_valid | output | 1 | Oldest instruction is free to issue |
| issue_ready | input | 1 | Downstream takes the instruction |
| issue_src | output | NSRC*RW | Source ids of the offered instruction |
| issue_src_en | output | NSRC | Source enables of the offered instruction |
| issue_dst | output | RW | Destination id of the offered instruction |
| issue_has_dst | output | 1 | Offered instruction writes a register |
| issue_payload | output | PW | Payload of the offered instruction |

## Verification
The two functions that collide are the writeback release and the issue decision: a completing write and a waiting consumer of that register meet in one cycle. The bench holds a consumer behind a pending id, then raises `wb_valid` for that id and, in the same cycle and before the edge, expects `issue_valid` high with the consumer's payload and takes it. A second case frees a slot with a writeback while a destination-carrying instruction waits on a full scoreboard. That case also shows the freed slot being claimed at once.

// File: rtl/wig_pkg.sv
package wig_pkg;

  // Upper bound on scoreboard slots handled by the helper below.
  localparam int unsigned WIG_MAX_SLOTS = 32;

  // Index of the lowest set bit; 0 if none is set.
  function automatic int unsigned lowest_set(logic [WIG_MAX_SLOTS-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = WIG_MAX_SLOTS - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // True when id a equals id b, both held in a 32-bit container.
  function automatic logic same_id(logic [31:0] a, logic [31:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/wig_fifo.sv
module wig_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         head_valid,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] fill_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_valid = (fill_q != '0);
  assign full       = (fill_q == CW'(DEPTH));
  assign head_data  = slot_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      fill_q <= fill_q + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);  // R4
  AST_STALL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == CW'(DEPTH - 1)) && push && !pop |=> full);  // R3

endmodule

// File: rtl/wig_scoreboard.sv
module wig_scoreboard
  import wig_pkg::*;
#(
  parameter int unsigned RW    = 5,
  parameter int unsigned SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_vld,
  input  logic [RW-1:0]     clr_id,
  input  logic              claim,
  input  logic [RW-1:0]     claim_id,
  output logic [SLOTS-1:0]  live_vld,
  output logic [SLOTS*RW-1:0] live_ids,
  output logic              has_free
);
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]  vld_q;
  logic [RW-1:0]     id_q [SLOTS];
  logic [SLOTS-1:0]  clr_hit;
  logic [SLOTS-1:0]  free_vec;
  logic [IW-1:0]     claim_idx;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      clr_hit[i] = clr_vld && vld_q[i] && same_id(32'(id_q[i]), 32'(clr_id));
    end
  end

  assign live_vld  = vld_q & ~clr_hit;
  assign free_vec  = ~live_vld;
  assign has_free  = |free_vec;
  assign claim_idx = IW'(lowest_set(WIG_MAX_SLOTS'(free_vec)));

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign live_ids[g*RW +: RW] = id_q[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          id_q[g]  <= '0;
        end else if (claim && (claim_idx == IW'(g))) begin
          vld_q[g] <= 1'b1;
          id_q[g]  <= claim_id;
        end else begin
          vld_q[g] <= live_vld[g];
        end
      end
    end
  endgenerate

  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |-> $countones(clr_hit) <= 1);  // R9
  AST_CLAIM_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> has_free);  // R8
  AST_CLAIM_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> $countones(vld_q) >= 1);  // R7

endmodule

// File: rtl/wig_hazard.sv
module wig_hazard
  import wig_pkg::*;
#(
  parameter int unsigned RW    = 5,
  parameter int unsigned NSRC  = 2,
  parameter int unsigned SLOTS = 4
) (
  input  logic [NSRC*RW-1:0]  src,
  input  logic [NSRC-1:0]     src_en,
  input  logic [RW-1:0]       dst,
  input  logic                has_dst,
  input  logic [SLOTS-1:0]    live_vld,
  input  logic [SLOTS*RW-1:0] live_ids,
  output logic [NSRC-1:0]     src_hit,
  output logic                dst_hit,
  output logic                blocked
);

  function automatic logic hits_any(logic [RW-1:0] id,
                                    logic [SLOTS-1:0] vld,
                                    logic [SLOTS*RW-1:0] ids);
    logic h;
    h = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && same_id(32'(ids[i*RW +: RW]), 32'(id))) h = 1'b1;
    end
    return h;
  endfunction

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      assign src_hit[s] = src_en[s] && hits_any(src[s*RW +: RW], live_vld, live_ids);
    end
  endgenerate

  assign dst_hit = has_dst && hits_any(dst, live_vld, live_ids);
  assign blocked = (|src_hit) || dst_hit;

endmodule

// File: rtl/warp_issue_gate.sv
module warp_issue_gate
  import wig_pkg::*;
#(
  parameter int unsigned RW         = 5,
  parameter int unsigned NSRC       = 2,
  parameter int unsigned PW         = 16,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned SB_ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [NSRC*RW-1:0] fetch_src,
  input  logic [NSRC-1:0]    fetch_src_en,
  input  logic [RW-1:0]      fetch_dst,
  input  logic               fetch_has_dst,
  input  logic [PW-1:0]      fetch_payload,
  output logic               fetch_stall,
  input  logic               wb_valid,
  input  logic [RW-1:0]      wb_reg,
  output logic               issue_valid,
  input  logic               issue_ready,
  output logic [NSRC*RW-1:0] issue_src,
  output logic [NSRC-1:0]    issue_src_en,
  output logic [RW-1:0]      issue_dst,
  output logic               issue_has_dst,
  output logic [PW-1:0]      issue_payload
);
  localparam int unsigned ENTRY_W = PW + 1 + RW + NSRC + NSRC * RW;

  // Named internal events for the assertions.
  logic               ev_accept;
  logic               ev_issue;
  logic               ev_claim;
  logic               head_valid;
  logic               buf_full;
  logic [ENTRY_W-1:0] head_entry;
  logic [SB_ENTRIES-1:0]    sb_live_vld;
  logic [SB_ENTRIES*RW-1:0] sb_live_ids;
  logic               sb_has_free;
  logic [NSRC-1:0]    src_hit;
  logic               dst_hit;
  logic               hazard;
  logic               slot_short;

  assign ev_accept   = fetch_valid && !buf_full;
  assign fetch_stall = buf_full;

  wig_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ev_accept),
    .push_data  ({fetch_payload, fetch_has_dst, fetch_dst, fetch_src_en, fetch_src}),
    .pop        (ev_issue),
    .head_data  (head_entry),
    .head_valid (head_valid),
    .full       (buf_full)
  );

  assign {issue_payload, issue_has_dst, issue_dst, issue_src_en, issue_src} = head_entry;

  wig_scoreboard #(.RW(RW), .SLOTS(SB_ENTRIES)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_vld  (wb_valid),
    .clr_id   (wb_reg),
    .claim    (ev_claim),
    .claim_id (issue_dst),
    .live_vld (sb_live_vld),
    .live_ids (sb_live_ids),
    .has_free (sb_has_free)
  );

  wig_hazard #(.RW(RW), .NSRC(NSRC), .SLOTS(SB_ENTRIES)) u_hz (
    .src      (issue_src),
    .src_en   (issue_src_en),
    .dst      (issue_dst),
    .has_dst  (issue_has_dst),
    .live_vld (sb_live_vld),
    .live_ids (sb_live_ids),
    .src_hit  (src_hit),
    .dst_hit  (dst_hit),
    .blocked  (hazard)
  );

  assign slot_short  = issue_has_dst && !sb_has_free;
  assign issue_valid = head_valid && !hazard && !slot_short;
  assign ev_issue    = issue_valid && issue_ready;
  assign ev_claim    = ev_issue && issue_has_dst;

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=> issue_valid && $stable(issue_payload)
      && $stable(issue_dst) && $stable(issue_src));  // R10
  AST_NO_ISSUE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |-> !(|src_hit) && !dst_hit);  // R5
  AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_stall && !ev_issue |=> fetch_stall);  // R3
  AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !issue_valid);  // R4

endmodule

// File: tb/warp_issue_gate_tb.sv
module warp_issue_gate_tb;
  localparam int RW = 5, NSRC = 2, PW = 16, DEPTH = 4, SBE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [NSRC*RW-1:0] fetch_src = '0;
  logic [NSRC-1:0] fetch_src_en = '0;
  logic [RW-1:0] fetch_dst = '0;
  logic fetch_has_dst = 1'b0;
  logic [PW-1:0] fetch_payload = '0;
  logic fetch_stall;
  logic wb_valid = 1'b0;
  logic [RW-1:0] wb_reg = '0;
  logic issue_valid;
  logic issue_ready = 1'b0;
  logic [NSRC*RW-1:0] issue_src;
  logic [NSRC-1:0] issue_src_en;
  logic [RW-1:0] issue_dst;
  logic issue_has_dst;
  logic [PW-1:0] issue_payload;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  warp_issue_gate #(.RW(RW), .NSRC(NSRC), .PW(PW), .DEPTH(DEPTH), .SB_ENTRIES(SBE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_src(fetch_src), .fetch_src_en(fetch_src_en),
    .fetch_dst(fetch_dst), .fetch_has_dst(fetch_has_dst), .fetch_payload(fetch_payload),
    .fetch_stall(fetch_stall), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_src(issue_src),
    .issue_src_en(issue_src_en), .issue_dst(issue_dst), .issue_has_dst(issue_has_dst),
    .issue_payload(issue_payload)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h, expected %0h", req, act, exp);
    end
  endtask

  // Wait for the edge, then move 1 ns past it.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(logic [RW-1:0] s0, logic [RW-1:0] s1, logic [1:0] en,
                      logic [RW-1:0] d, logic hd, logic [PW-1:0] pl);
    fetch_valid = 1'b1;
    fetch_src = {s1, s0};
    fetch_src_en = en;
    fetch_dst = d;
    fetch_has_dst = hd;
    fetch_payload = pl;
    cyc();
    fetch_valid = 1'b0;
  endtask

  task automatic take(string req, logic [PW-1:0] pl);
    #1;
    chk({req, " valid"}, 32'(issue_valid), 32'd1);
    chk({req, " payload"}, 32'(issue_payload), 32'(pl));
    issue_ready = 1'b1;
    cyc();
    issue_ready = 1'b0;
  endtask

  task automatic held(string req);
    #1;
    chk({req, " held"}, 32'(issue_valid), 32'd0);
  endtask

  task automatic wb_pulse(logic [RW-1:0] id);
    wb_valid = 1'b1;
    wb_reg = id;
    cyc();
    wb_valid = 1'b0;
  endtask

  task automatic pass_dst(logic [RW-1:0] d, logic [PW-1:0] pl, string req);
    push('0, '0, 2'b00, d, 1'b1, pl);
    take(req, pl);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    #1;
    chk("R1 issue_valid after reset", 32'(issue_valid), 32'd0);
    chk("R1 fetch_stall after reset", 32'(fetch_stall), 32'd0);
    cyc();
  endtask

  task automatic t_fill_order();
    for (int i = 1; i <= DEPTH; i++) push('0, '0, 2'b00, '0, 1'b0, PW'(i));
    #1;
    chk("R3 stall when full", 32'(fetch_stall), 32'd1);
    push('0, '0, 2'b00, '0, 1'b0, 16'h00EE);
    for (int i = 1; i <= DEPTH; i++) take("R2 R4 fifo order", PW'(i));
    #1;
    chk("R3 dropped fetch absent", 32'(issue_valid), 32'd0);
    chk("R3 stall released", 32'(fetch_stall), 32'd0);
  endtask

  task automatic t_raw_sameclr();
    pass_dst(5'd5, 16'h0010, "R7 producer");
    push(5'd5, '0, 2'b01, '0, 1'b0, 16'h0011);
    push('0, '0, 2'b00, '0, 1'b0, 16'h0012);
    held("R5 R4 consumer blocks younger");
    wb_valid = 1'b1;
    wb_reg = 5'd5;
    #1;
    chk("R9 same-cycle release valid", 32'(issue_valid), 32'd1);
    chk("R9 same-cycle release payload", 32'(issue_payload), 32'h0011);
    issue_ready = 1'b1;
    cyc();
    issue_ready = 1'b0;
    wb_valid = 1'b0;
    take("R4 younger follows", 16'h0012);
  endtask

  task automatic t_waw();
    pass_dst(5'd7, 16'h0020, "R7 first writer");
    push('0, '0, 2'b00, 5'd7, 1'b1, 16'h0021);
    held("R6 second writer");
    wb_pulse(5'd7);
    take("R6 after release", 16'h0021);
    wb_pulse(5'd7);
  endtask

  task automatic t_full_sb();
    for (int i = 1; i <= SBE; i++) pass_dst(RW'(i), PW'(16'h0030 + i), "R7 fill slots");
    push('0, '0, 2'b00, '0, 1'b0, 16'h0035);
    take("R8 no-dst passes full scoreboard", 16'h0035);
    push('0, '0, 2'b00, 5'd9, 1'b1, 16'h0036);
    held("R8 dst waits for slot");
    wb_valid = 1'b1;
    wb_reg = 5'd2;
    #1;
    chk("R9 R8 freed slot usable", 32'(issue_valid), 32'd1);
    issue_ready = 1'b1;
    cyc();
    issue_ready = 1'b0;
    wb_valid = 1'b0;
    push(5'd2, '0, 2'b01, '0, 1'b0, 16'h0037);
    take("R9 released id no longer blocks", 16'h0037);
    push('0, 5'd9, 2'b10, '0, 1'b0, 16'h0038);
    held("R7 R5 new pending id on second source");
    wb_pulse(5'd9);
    take("R9 release of 9", 16'h0038);
    push(5'd3, '0, 2'b00, '0, 1'b0, 16'h003A);
    take("R11 disabled source ignored", 16'h003A);
    push(5'd3, '0, 2'b01, '0, 1'b0, 16'h003B);
    held("R5 enabled source blocks");
    wb_pulse(5'd3);
    take("R9 release of 3", 16'h003B);
    wb_pulse(5'd1);
    wb_pulse(5'd4);
  endtask

  task automatic t_hold();
    push(5'd1, 5'd2, 2'b11, 5'd6, 1'b1, 16'h0040);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 valid held", 32'(issue_valid), 32'd1);
      chk("R10 payload held", 32'(issue_payload), 32'h0040);
      chk("R10 dst held", 32'(issue_dst), 32'd6);
      cyc();
    end
    take("R10 finally taken", 16'h0040);
  endtask

  task automatic t_reset_clears();
    pass_dst(5'd12, 16'h0050, "R7 before reset");
    push(5'd12, '0, 2'b01, '0, 1'b0, 16'h0051);
    held("R5 before reset");
    t_reset();
    push(5'd12, '0, 2'b01, '0, 1'b0, 16'h0052);
    take("R1 pending id cleared by reset", 16'h0052);
  endtask

  initial begin
    t_reset();
    t_fill_order();
    t_raw_sameclr();
    t_waw();
    t_full_sb();
    t_hold();
    t_reset_clears();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule